// File: doc/BRIEF.md
# Shadowed Control Register Bank

This block holds a small page of control registers in which two configuration registers are backed twice: a working copy that drives the rest of the chip, and a persistent backing copy that survives a reset. A byte-write port carries an address and a data byte. A persistence bit in the mode register decides where a write to a backed register goes. When the bit is set, the write goes to both copies. When it is clear, the write goes to the working copy only, and the value is lost at the next reset.

After every reset the block copies each backing copy into its working copy. While persistence is off, a write to the mode register or to the auxiliary register also reloads both working copies from their backing copies. The persistence bit that counts is the one held before that write. An active-low write-protect input blocks every write, and with it any reload that a write would trigger. The backing storage is modelled as flops that keep their value through reset. Commit timing is not modelled.

Top module: `shadow_ctrl_bank`

## Requirements
- R1: While rst_ni is low, mode_o and aux_o hold 8'h00, and cfg_a_o and cfg_b_o read 8'h00.
- R2: At the first rising clock edge after rst_ni goes high, cfg_a_o and cfg_b_o load the backing copies. These start at 8'h5A and 8'hC3 and keep their values across reset. Any write presented in that first cycle is ignored.
- R3: A write to address 80h stores the data in mode_o, and a write to 85h stores it in aux_o. The new value is visible after the same edge.
- R4: When mode_o[7] is 1, a write to 81h (register A) or 83h (register B) updates both the working copy and the backing copy of that register.
- R5: When mode_o[7] is 0, a write to 81h or 83h updates only the working copy. The backing copy is unchanged, so the next reset restores the old value.
- R6: When mode_o[7] is 0 before the edge, a write to 80h or 85h reloads cfg_a_o and cfg_b_o from their backing copies at that edge. This holds even when the written data sets bit 7.
- R7: When mode_o[7] is 1 before the edge, a write to 80h or 85h leaves cfg_a_o and cfg_b_o unchanged.
- R8: While wp_ni is low, every write is ignored: no register, working copy or backing copy changes, and no reload occurs.
- R9: A write to any address other than 80h, 81h, 83h and 85h changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| wr_en_i | input | 1 | Byte write strobe |
| wr_addr_i | input | 8 | Write address |
| wr_data_i | input | 8 | Write data |
| wp_ni | input | 1 | Write protect, active low |
| mode_o | output | 8 | Mode register; bit 7 selects write-through persistence |
| aux_o | output | 8 | Auxiliary control register |
| cfg_a_o | output | 8 | Effective (working) value of backed register A |
| cfg_b_o | output | 8 | Effective (working) value of backed register B |

## Verification
Directed write sequences run first.

- **Write routing.** The same backed-register writes are made under both persistence settings. A reset pulse after each one shows whether the value reached the backing copy or only the working copy.
- **Reload trigger.** Writes to the mode and aux registers, with persistence off and then on, separate a reload from a plain store. A mode write that sets bit 7 from a cleared state shows which bit value decides the reload.
- **Protection and address misses.** Writes held off by write protect, and writes to unmapped addresses, are checked for leaving every output unchanged.

A pseudo-random stream of mixed addresses and protect levels then mixes these cases back to back.

// File: rtl/shadow_bank_pkg.sv
package shadow_bank_pkg;
  typedef struct packed {
    logic mode;
    logic aux;
    logic sh_a;
    logic sh_b;
  } hit_t;

  localparam int unsigned NUM_SHADOW = 2;
endpackage

// File: rtl/shadow_bank_decode.sv
module shadow_bank_decode
  import shadow_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE     = 8'h80,
  parameter logic [ADDR_W-1:0] OFF_MODE = 8'h00,
  parameter logic [ADDR_W-1:0] OFF_A    = 8'h01,
  parameter logic [ADDR_W-1:0] OFF_B    = 8'h03,
  parameter logic [ADDR_W-1:0] OFF_AUX  = 8'h05
) (
  input  logic [ADDR_W-1:0] addr_i,
  output hit_t              hit_o
);
  localparam logic [ADDR_W-1:0] A_MODE = BASE + OFF_MODE;
  localparam logic [ADDR_W-1:0] A_A    = BASE + OFF_A;
  localparam logic [ADDR_W-1:0] A_B    = BASE + OFF_B;
  localparam logic [ADDR_W-1:0] A_AUX  = BASE + OFF_AUX;

  always_comb begin
    hit_o.mode = (addr_i == A_MODE);
    hit_o.aux  = (addr_i == A_AUX);
    hit_o.sh_a = (addr_i == A_A);
    hit_o.sh_b = (addr_i == A_B);
  end
endmodule

// File: rtl/shadow_bank_cell.sv
module shadow_bank_cell #(
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] NV_INIT = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              recall_i,
  input  logic              wr_i,
  input  logic              persist_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] vol_o,
  output logic [DATA_W-1:0] nv_o
);
  // backing copy: no reset, keeps contents across power-on reset
  logic [DATA_W-1:0] nv_q = NV_INIT;
  logic [DATA_W-1:0] vol_q;

  always_ff @(posedge clk_i) begin
    if (wr_i && persist_i) nv_q <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       vol_q <= '0;
    else if (recall_i) vol_q <= nv_q;
    else if (wr_i)     vol_q <= data_i;
  end

  assign vol_o = vol_q;
  assign nv_o  = nv_q;
endmodule

// File: rtl/shadow_bank_plain_reg.sv
module shadow_bank_plain_reg #(
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST_VAL;
    else if (wr_i) q_o <= data_i;
  end
endmodule

// File: rtl/shadow_ctrl_bank.sv
module shadow_ctrl_bank
  import shadow_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned MODE_BIT = 7,
  parameter logic [ADDR_W-1:0] BASE     = 8'h80,
  parameter logic [ADDR_W-1:0] OFF_MODE = 8'h00,
  parameter logic [ADDR_W-1:0] OFF_A    = 8'h01,
  parameter logic [ADDR_W-1:0] OFF_B    = 8'h03,
  parameter logic [ADDR_W-1:0] OFF_AUX  = 8'h05,
  parameter logic [DATA_W-1:0] MODE_RST = 8'h00,
  parameter logic [DATA_W-1:0] AUX_RST  = 8'h00,
  parameter logic [DATA_W-1:0] NV_A_INIT = 8'h5A,
  parameter logic [DATA_W-1:0] NV_B_INIT = 8'hC3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wp_ni,
  output logic [DATA_W-1:0] mode_o,
  output logic [DATA_W-1:0] aux_o,
  output logic [DATA_W-1:0] cfg_a_o,
  output logic [DATA_W-1:0] cfg_b_o
);
  localparam logic [DATA_W-1:0] NV_INIT_ARR [NUM_SHADOW] = '{NV_A_INIT, NV_B_INIT};

  hit_t              hit;
  logic              por_q;
  logic              wr_ok;
  logic              persist;
  logic              recall;
  logic              sh_hit [NUM_SHADOW];
  logic [DATA_W-1:0] vol_q  [NUM_SHADOW];
  logic [DATA_W-1:0] nv_q   [NUM_SHADOW];

  shadow_bank_decode #(
    .ADDR_W(ADDR_W), .BASE(BASE), .OFF_MODE(OFF_MODE),
    .OFF_A(OFF_A), .OFF_B(OFF_B), .OFF_AUX(OFF_AUX)
  ) u_dec (
    .addr_i(wr_addr_i),
    .hit_o (hit)
  );

  // one-cycle recall window after power-on reset; writes held off
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) por_q <= 1'b1;
    else         por_q <= 1'b0;
  end

  assign wr_ok   = wr_en_i & wp_ni & ~por_q;
  assign persist = mode_o[MODE_BIT];  // pre-write value
  assign recall  = por_q | (wr_ok & (hit.mode | hit.aux) & ~persist);

  assign sh_hit[0] = hit.sh_a;
  assign sh_hit[1] = hit.sh_b;

  shadow_bank_plain_reg #(.DATA_W(DATA_W), .RST_VAL(MODE_RST)) u_mode (
    .clk_i, .rst_ni, .wr_i(wr_ok & hit.mode), .data_i(wr_data_i), .q_o(mode_o)
  );

  shadow_bank_plain_reg #(.DATA_W(DATA_W), .RST_VAL(AUX_RST)) u_aux (
    .clk_i, .rst_ni, .wr_i(wr_ok & hit.aux), .data_i(wr_data_i), .q_o(aux_o)
  );

  for (genvar g = 0; g < NUM_SHADOW; g++) begin : g_sh
    shadow_bank_cell #(.DATA_W(DATA_W), .NV_INIT(NV_INIT_ARR[g])) u_cell (
      .clk_i,
      .rst_ni,
      .recall_i (recall),
      .wr_i     (wr_ok & sh_hit[g]),
      .persist_i(persist),
      .data_i   (wr_data_i),
      .vol_o    (vol_q[g]),
      .nv_o     (nv_q[g])
    );
  end

  assign cfg_a_o = vol_q[0];
  assign cfg_b_o = vol_q[1];
endmodule

// File: rtl/shadow_ctrl_bank_chk.sv
module shadow_ctrl_bank_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned MODE_BIT = 7,
  parameter logic [ADDR_W-1:0] BASE     = 8'h80,
  parameter logic [ADDR_W-1:0] OFF_MODE = 8'h00,
  parameter logic [ADDR_W-1:0] OFF_A    = 8'h01,
  parameter logic [ADDR_W-1:0] OFF_B    = 8'h03,
  parameter logic [ADDR_W-1:0] OFF_AUX  = 8'h05
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              wp_ni,
  input logic [DATA_W-1:0] mode_o,
  input logic [DATA_W-1:0] aux_o,
  input logic [DATA_W-1:0] cfg_a_o,
  input logic [DATA_W-1:0] cfg_b_o,
  input logic              por_i,
  input logic [DATA_W-1:0] nv_a_i,
  input logic [DATA_W-1:0] nv_b_i
);
  localparam logic [ADDR_W-1:0] C_MODE = BASE + OFF_MODE;
  localparam logic [ADDR_W-1:0] C_A    = BASE + OFF_A;
  localparam logic [ADDR_W-1:0] C_B    = BASE + OFF_B;
  localparam logic [ADDR_W-1:0] C_AUX  = BASE + OFF_AUX;

  logic go, pst, mapped;
  assign go     = wr_en_i && wp_ni && !por_i;
  assign pst    = mode_o[MODE_BIT];
  assign mapped = (wr_addr_i == C_MODE) || (wr_addr_i == C_A) ||
                  (wr_addr_i == C_B) || (wr_addr_i == C_AUX);

  AST_POR_RECALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> (cfg_a_o == $past(nv_a_i)) && (cfg_b_o == $past(nv_b_i))); // R2
  AST_MODE_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go && (wr_addr_i == C_MODE) |=> mode_o == $past(wr_data_i)); // R3
  AST_AUX_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go && (wr_addr_i == C_AUX) |=> aux_o == $past(wr_data_i)); // R3
  AST_WRITE_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go && pst && (wr_addr_i == C_A) |=> (cfg_a_o == $past(wr_data_i)) && (nv_a_i == $past(wr_data_i))); // R4
  AST_VOLATILE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go && !pst && (wr_addr_i == C_B) |=> (cfg_b_o == $past(wr_data_i)) && $stable(nv_b_i)); // R5
  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go && !pst && ((wr_addr_i == C_MODE) || (wr_addr_i == C_AUX))
    |=> (cfg_a_o == $past(nv_a_i)) && (cfg_b_o == $past(nv_b_i))); // R6
  AST_NO_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go && pst && ((wr_addr_i == C_MODE) || (wr_addr_i == C_AUX))
    |=> $stable(cfg_a_o) && $stable(cfg_b_o)); // R7
  AST_WP_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wp_ni && !por_i |=> $stable({mode_o, aux_o, cfg_a_o, cfg_b_o, nv_a_i, nv_b_i})); // R8
  AST_ADDR_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !por_i && !mapped |=> $stable({mode_o, aux_o, cfg_a_o, cfg_b_o, nv_a_i, nv_b_i})); // R9
endmodule

bind shadow_ctrl_bank shadow_ctrl_bank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_BIT(MODE_BIT), .BASE(BASE),
  .OFF_MODE(OFF_MODE), .OFF_A(OFF_A), .OFF_B(OFF_B), .OFF_AUX(OFF_AUX)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .wp_ni(wp_ni), .mode_o(mode_o), .aux_o(aux_o),
  .cfg_a_o(cfg_a_o), .cfg_b_o(cfg_b_o), .por_i(por_q),
  .nv_a_i(nv_q[0]), .nv_b_i(nv_q[1])
);

// File: tb/tb_shadow_ctrl_bank.sv
`timescale 1ns/1ps
module tb_shadow_ctrl_bank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = 8'h00;
  logic [7:0] wr_data = 8'h00;
  logic       wp_n = 1'b1;
  logic [7:0] mode_o, aux_o, cfg_a_o, cfg_b_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string tag = "R1";

  // reference model state
  logic [7:0] m_mode, m_aux, m_a, m_b;
  logic [7:0] m_nva = 8'h5A;
  logic [7:0] m_nvb = 8'hC3;
  bit         m_por;
  logic [7:0] wlog [$];

  always #2.5 clk = ~clk;

  shadow_ctrl_bank dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .wp_ni(wp_n), .mode_o(mode_o), .aux_o(aux_o),
    .cfg_a_o(cfg_a_o), .cfg_b_o(cfg_b_o)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 8'h00; m_aux = 8'h00; m_a = 8'h00; m_b = 8'h00; m_por = 1'b1;
    end else if (m_por) begin
      m_a = m_nva; m_b = m_nvb; m_por = 1'b0;
    end else if (wr_en && wp_n) begin
      bit keep;
      keep = m_mode[7];
      wlog.push_back(wr_addr);
      case (wr_addr)
        8'h80: begin m_mode = wr_data; if (!keep) begin m_a = m_nva; m_b = m_nvb; end end
        8'h85: begin m_aux = wr_data;  if (!keep) begin m_a = m_nva; m_b = m_nvb; end end
        8'h81: begin m_a = wr_data; if (keep) m_nva = wr_data; end
        8'h83: begin m_b = wr_data; if (keep) m_nvb = wr_data; end
        default: ;
      endcase
    end
  end

  task automatic chk1(input string nm, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk1("mode_o", mode_o, m_mode);
    chk1("aux_o", aux_o, m_aux);
    chk1("cfg_a_o", cfg_a_o, m_a);
    chk1("cfg_b_o", cfg_b_o, m_b);
  endtask

  // drive one cycle at negedge, compare at next negedge
  task automatic cyc(input bit en, input logic [7:0] a, input logic [7:0] d, input bit wp);
    wr_en = en; wr_addr = a; wr_data = d; wp_n = wp;
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    cyc(1'b0, 8'h00, 8'h00, 1'b1);
  endtask

  task automatic por_pulse();
    wr_en = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    compare();          // R1 values held in reset
    rst_n = 1'b1;
  endtask

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    @(negedge clk); @(negedge clk);
    tag = "R1"; compare();
    rst_n = 1'b1;
    // R2: write in the recall cycle is ignored; recall loads 5A/C3
    tag = "R2"; cyc(1'b1, 8'h81, 8'h11, 1'b1);
    chk1("R2 cfg_a after recall", cfg_a_o, 8'h5A);
    chk1("R2 cfg_b after recall", cfg_b_o, 8'hC3);
    idle();
    // R5: volatile-only writes
    tag = "R5"; cyc(1'b1, 8'h81, 8'hAA, 1'b1); cyc(1'b1, 8'h83, 8'hBB, 1'b1);
    chk1("R5 cfg_a volatile", cfg_a_o, 8'hAA);
    // R6: aux write reloads
    tag = "R6"; cyc(1'b1, 8'h85, 8'h01, 1'b1);
    chk1("R6 cfg_a reloaded", cfg_a_o, 8'h5A);
    chk1("R3 aux stored", aux_o, 8'h01);
    // R5: volatile value lost at reset
    tag = "R5"; cyc(1'b1, 8'h81, 8'h12, 1'b1);
    tag = "R1"; por_pulse();
    tag = "R5"; idle();
    chk1("R5 lost after reset", cfg_a_o, 8'h5A);
    // R6: mode write setting bit 7 still reloads (old bit 0)
    tag = "R5"; cyc(1'b1, 8'h83, 8'h21, 1'b1);
    tag = "R6"; cyc(1'b1, 8'h80, 8'h80, 1'b1);
    chk1("R6 cfg_b reloaded on mode write", cfg_b_o, 8'hC3);
    chk1("R3 mode stored", mode_o, 8'h80);
    // R4: write-through
    tag = "R4"; cyc(1'b1, 8'h81, 8'h77, 1'b1); cyc(1'b1, 8'h83, 8'h66, 1'b1);
    // R7: no reload when persistence on
    tag = "R7"; cyc(1'b1, 8'h85, 8'h02, 1'b1);
    chk1("R7 cfg_a kept", cfg_a_o, 8'h77);
    cyc(1'b1, 8'h80, 8'h00, 1'b1);
    chk1("R7 cfg_b kept", cfg_b_o, 8'h66);
    tag = "R5"; cyc(1'b1, 8'h81, 8'h33, 1'b1);
    tag = "R6"; cyc(1'b1, 8'h85, 8'h03, 1'b1);
    chk1("R4 backing A persisted", cfg_a_o, 8'h77);
    // R8: write protect
    tag = "R5"; cyc(1'b1, 8'h81, 8'h44, 1'b1);
    tag = "R8";
    cyc(1'b1, 8'h85, 8'hFF, 1'b0);
    chk1("R8 no reload under protect", cfg_a_o, 8'h44);
    cyc(1'b1, 8'h80, 8'h80, 1'b0);
    chk1("R8 mode unchanged", mode_o, 8'h00);
    cyc(1'b1, 8'h83, 8'h99, 1'b0);
    chk1("R8 cfg_b unchanged", cfg_b_o, 8'h66);
    // R9: unmapped addresses
    tag = "R9";
    cyc(1'b1, 8'h82, 8'h5F, 1'b1); cyc(1'b1, 8'h84, 8'h5F, 1'b1);
    cyc(1'b1, 8'h01, 8'h5F, 1'b1); cyc(1'b1, 8'h86, 8'h5F, 1'b1);
    chk1("R9 cfg_a unchanged", cfg_a_o, 8'h44);
    // R2: backing copies survive reset
    tag = "R1"; por_pulse();
    tag = "R2"; idle();
    chk1("R2 cfg_a from backing", cfg_a_o, 8'h77);
    chk1("R2 cfg_b from backing", cfg_b_o, 8'h66);
    // mixed stream
    tag = "R3";
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[2:0])
        3'd0, 3'd1: a = 8'h81;
        3'd2, 3'd3: a = 8'h83;
        3'd4:       a = 8'h80;
        3'd5:       a = 8'h85;
        default:    a = 8'h82;
      endcase
      cyc(lfsr[3] | lfsr[4], a, lfsr[15:8], lfsr[7:5] != 3'd0);
      if (i == 200) begin tag = "R1"; por_pulse(); tag = "R3"; end
    end
    if (wlog.size() == 0) chk1("R3 writes seen", 8'h00, 8'h01);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule